// File: doc/BRIEF.md
# Final Round-Key Generator

This block takes the 80-bit user key of a lightweight 64-bit substitution-permutation cipher and advances its key schedule, one round per clock, to the last round key. A decryption datapath, which consumes round keys in reverse order, uses this final key as its starting point and walks the schedule backwards on its own.

The user raises `start` with a key on `key` and keeps `start` high. On the first clock edge that sees `start` while the block is idle, the key is captured. Thirty-one schedule updates follow, with round indices 1 through 31. Then `ready` rises and `key_end` holds the final key. Lowering `start` for at least one cycle returns the block to idle. Raising `start` again begins a fresh run with whatever key is on the input at that moment. Nothing from an earlier run carries into the next one.

Top module: `final_rkey_gen`

## Requirements
- R1: While `rst_n` is sampled low at a clock edge (synchronous, active low), the block returns to idle, and after that edge `ready` is 0 and `key_end` is all zeros.
- R2: On the first clock edge where `start` is high and the block is idle, `key` is loaded, so `key_end` equals that key after the edge.
- R3: Each later edge in a run with `start` high applies one schedule round to `key_end`. The round has three steps in this order. First, rotate the 80-bit value left by 61 positions. Second, replace bits 79:76 with S(bits 79:76), where S maps 0..F to C,5,6,B,9,0,A,D,3,E,F,8,4,7,1,2. Third, XOR the 5-bit round index into bits 19:15. The round index is 1 on the first update and rises by one per update.
- R4: After exactly 31 updates, `ready` rises. It is first seen high after the 32nd clock edge counted from the load edge inclusive.
- R5: An all-zero key gives the final key 0x6dab31744f41d7008759.
- R6: An all-ones key gives the final key 0xfe7a548fb60eb167c511.
- R7: While `start` stays high after `ready` has risen, `ready` stays 1 and `key_end` does not change.
- R8: After an edge that sees `start` low while `ready` is 1, `ready` is 0. While the block is idle with `start` low, `key_end` keeps its value.
- R9: Repeated runs with the same key give identical final keys, whatever ran before them.
- R10: If `start` is sampled low during a run, the run is abandoned. The block returns to idle with `ready` low, and the next high `start` reloads the key and begins again from round 1.
- R11: Changes on `key` after the load edge have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Level request; held high for a whole run |
| key | input | 80 | User key, sampled on the load edge |
| key_end | output | 80 | Schedule register; holds the final key when ready is high |
| ready | output | 1 | Final key valid |

## Verification
Two situations are hard to reach from the ports: a run abandoned partway through, and a key input that changes after it has been captured. Both depend on when `start` and `key` move relative to the round count. The stimulus therefore drops `start` at a chosen round, and in another run switches `key` while the run is in progress. A behavioural model, stepped on every clock, has to agree with `key_end` and `ready` after each of these disturbances. The run that follows the disturbance must still produce the known final keys.

// File: rtl/frk_pkg.sv
// Shared types and the 4-bit substitution for the final round-key generator.
// Assumes: the substitution box is fixed at 4 bits in and 4 bits out.
package frk_pkg;

    typedef enum logic [1:0] {
        FRK_IDLE = 2'd0,
        FRK_RUN  = 2'd1,
        FRK_DONE = 2'd2
    } frk_state_t;

    // Purpose: the cipher's 4-bit nonlinear substitution.
    function automatic logic [3:0] frk_sbox(input logic [3:0] x);
        logic [3:0] y;
        case (x)
            4'h0: y = 4'hC;
            4'h1: y = 4'h5;
            4'h2: y = 4'h6;
            4'h3: y = 4'hB;
            4'h4: y = 4'h9;
            4'h5: y = 4'h0;
            4'h6: y = 4'hA;
            4'h7: y = 4'hD;
            4'h8: y = 4'h3;
            4'h9: y = 4'hE;
            4'hA: y = 4'hF;
            4'hB: y = 4'h8;
            4'hC: y = 4'h4;
            4'hD: y = 4'h7;
            4'hE: y = 4'h1;
            default: y = 4'h2;
        endcase
        return y;
    endfunction

endpackage

// File: rtl/frk_round.sv
// One combinational key-schedule round: rotate left by ROT, substitute the
// top nibble, XOR the round index into the field starting at CNT_LSB.
// Assumes: ROT < KEY_W, and CNT_LSB + CNT_W <= KEY_W - 4.
module frk_round #(
    parameter int KEY_W   = 80,
    parameter int CNT_W   = 5,
    parameter int ROT     = 61,
    parameter int CNT_LSB = 15
) (
    input  logic [KEY_W-1:0] key_in,
    input  logic [CNT_W-1:0] round_idx,
    output logic [KEY_W-1:0] key_out
);
    import frk_pkg::*;

    localparam int NIB_LSB = KEY_W - 4;

    logic [KEY_W-1:0] rotated;
    logic [KEY_W-1:0] substituted;

    // Purpose: fixed left rotation of the whole register.
    always_comb begin
        rotated = {key_in[KEY_W-ROT-1:0], key_in[KEY_W-1:KEY_W-ROT]};
    end

    // Purpose: pass the most significant nibble through the substitution.
    always_comb begin
        substituted = rotated;
        substituted[KEY_W-1:NIB_LSB] = frk_sbox(rotated[KEY_W-1:NIB_LSB]);
    end

    // Purpose: mix each round-index bit into its own key bit.
    generate
        for (genvar b = 0; b < KEY_W; b++) begin : g_mix
            if (b >= CNT_LSB && b < CNT_LSB + CNT_W) begin : g_xor
                assign key_out[b] = substituted[b] ^ round_idx[b-CNT_LSB];
            end else begin : g_pass
                assign key_out[b] = substituted[b];
            end
        end
    endgenerate

endmodule

// File: rtl/frk_ctrl.sv
// Control state machine and round counter. Idle until start is seen, then
// one update per cycle for ROUNDS cycles, then done until start falls.
// Assumes: ROUNDS fits in CNT_W bits; start is a synchronous level.
module frk_ctrl #(
    parameter int CNT_W  = 5,
    parameter int ROUNDS = 31
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    output logic                  load,
    output logic                  step,
    output logic                  done,
    output frk_pkg::frk_state_t   state_o,
    output logic [CNT_W-1:0]      round_o
);
    import frk_pkg::*;

    localparam logic [CNT_W-1:0] LAST  = CNT_W'(ROUNDS);
    localparam logic [CNT_W-1:0] FIRST = CNT_W'(1);

    frk_state_t       state_q, state_d;
    logic [CNT_W-1:0] round_q, round_d;

    // Purpose: next-state, next-count and datapath strobes.
    always_comb begin
        state_d = state_q;
        round_d = round_q;
        load    = 1'b0;
        step    = 1'b0;
        case (state_q)
            FRK_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    round_d = FIRST;
                    state_d = FRK_RUN;
                end
            end
            FRK_RUN: begin
                if (!start) begin
                    round_d = '0;
                    state_d = FRK_IDLE;
                end else begin
                    step = 1'b1;
                    if (round_q == LAST) begin
                        round_d = '0;
                        state_d = FRK_DONE;
                    end else begin
                        round_d = round_q + FIRST;
                    end
                end
            end
            FRK_DONE: begin
                if (!start) begin
                    state_d = FRK_IDLE;
                end
            end
            default: begin
                round_d = '0;
                state_d = FRK_IDLE;
            end
        endcase
    end

    // Purpose: state and counter registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FRK_IDLE;
            round_q <= '0;
        end else begin
            state_q <= state_d;
            round_q <= round_d;
        end
    end

    assign done    = (state_q == FRK_DONE);
    assign state_o = state_q;
    assign round_o = round_q;

endmodule

// File: rtl/frk_keyreg.sv
// Key-schedule register: loads the user key or takes the next round value.
// Assumes: load and step are never high together.
module frk_keyreg #(
    parameter int KEY_W = 80
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [KEY_W-1:0] key_in,
    input  logic [KEY_W-1:0] next_in,
    output logic [KEY_W-1:0] key_q
);
    // Purpose: hold, load or advance the schedule value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            key_q <= '0;
        end else if (load) begin
            key_q <= key_in;
        end else if (step) begin
            key_q <= next_in;
        end
    end

endmodule

// File: rtl/final_rkey_gen.sv
// Final round-key generator: advances the 80-bit key schedule from the user
// key to the last round key, one round per clock, under a level handshake.
// Assumes: start is held high for a whole run; key is sampled once per run.
module final_rkey_gen #(
    parameter int KEY_W   = 80,
    parameter int CNT_W   = 5,
    parameter int ROUNDS  = 31,
    parameter int ROT     = 61,
    parameter int CNT_LSB = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [KEY_W-1:0] key,
    output logic [KEY_W-1:0] key_end,
    output logic             ready
);
    import frk_pkg::*;

    logic             load;
    logic             step;
    logic             done;
    frk_state_t       fsm_state;
    logic [CNT_W-1:0] round_idx;
    logic [KEY_W-1:0] sched_q;
    logic [KEY_W-1:0] sched_next;

    frk_ctrl #(
        .CNT_W  (CNT_W),
        .ROUNDS (ROUNDS)
    ) i_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .step    (step),
        .done    (done),
        .state_o (fsm_state),
        .round_o (round_idx)
    );

    frk_round #(
        .KEY_W   (KEY_W),
        .CNT_W   (CNT_W),
        .ROT     (ROT),
        .CNT_LSB (CNT_LSB)
    ) i_round (
        .key_in    (sched_q),
        .round_idx (round_idx),
        .key_out   (sched_next)
    );

    frk_keyreg #(
        .KEY_W (KEY_W)
    ) i_keyreg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .step    (step),
        .key_in  (key),
        .next_in (sched_next),
        .key_q   (sched_q)
    );

    assign key_end = sched_q;
    assign ready   = done;

endmodule

// File: rtl/final_rkey_gen_chk.sv
// Checker for final_rkey_gen: temporal properties of the handshake, the
// load and the round counter. Attached by the bind at the end of this file.
module final_rkey_gen_chk #(
    parameter int KEY_W  = 80,
    parameter int CNT_W  = 5,
    parameter int ROUNDS = 31
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [KEY_W-1:0]    key,
    input logic [KEY_W-1:0]    key_end,
    input logic                ready,
    input frk_pkg::frk_state_t state_q,
    input logic [CNT_W-1:0]    round_q
);
    import frk_pkg::*;

    localparam logic [CNT_W-1:0] LAST = CNT_W'(ROUNDS);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!ready && key_end == '0));

    assert_load_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRK_IDLE && start) |=> (key_end == $past(key) && round_q == CNT_W'(1)));

    assert_round_advance_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRK_RUN && start && round_q != LAST) |=> (round_q == $past(round_q) + CNT_W'(1)));

    assert_round_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRK_RUN) |-> (round_q >= CNT_W'(1) && round_q <= LAST));

    assert_ready_after_last_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRK_RUN && start && round_q == LAST) |=> ready);

    assert_ready_only_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (state_q == FRK_DONE));

    assert_ready_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && start) |=> (ready && $stable(key_end)));

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !start) |=> !ready);

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRK_IDLE && !start) |=> $stable(key_end));

    assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FRK_RUN && !start) |=> (state_q == FRK_IDLE && !ready));

endmodule

bind final_rkey_gen final_rkey_gen_chk #(
    .KEY_W  (KEY_W),
    .CNT_W  (CNT_W),
    .ROUNDS (ROUNDS)
) i_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .key     (key),
    .key_end (key_end),
    .ready   (ready),
    .state_q (fsm_state),
    .round_q (round_idx)
);

// File: tb/test_final_rkey_gen.sv
module test_final_rkey_gen;

    localparam logic [79:0] EXP_ZERO = 80'h6dab31744f41d7008759;
    localparam logic [79:0] EXP_ONES = 80'hfe7a548fb60eb167c511;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [79:0] key = '0;
    logic [79:0] key_end;
    logic        ready;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    final_rkey_gen i_final_rkey_gen (
        .clk(clk), .rst_n(rst_n), .start(start),
        .key(key), .key_end(key_end), .ready(ready)
    );

    // Behavioural reference model: phase 0 idle, 1..31 next round, 32 done.
    int          m_phase = 0;
    logic [79:0] m_key = '0;
    logic [3:0]  sb [16] = '{4'hC,4'h5,4'h6,4'hB,4'h9,4'h0,4'hA,4'hD,
                             4'h3,4'hE,4'hF,4'h8,4'h4,4'h7,4'h1,4'h2};

    function automatic logic [79:0] ref_round(input logic [79:0] k, input int r);
        logic [79:0] v = k;
        for (int i = 0; i < 61; i++) v = {v[78:0], v[79]};
        v[79:76] = sb[v[79:76]];
        for (int i = 0; i < 5; i++) v[15+i] = v[15+i] ^ r[i];
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_phase <= 0;
            m_key   <= '0;
        end else if (m_phase == 0) begin
            if (start) begin
                m_key   <= key;
                m_phase <= 1;
            end
        end else if (m_phase <= 31) begin
            if (!start) m_phase <= 0;
            else begin
                m_key   <= ref_round(m_key, m_phase);
                m_phase <= m_phase + 1;
            end
        end else if (!start) begin
            m_phase <= 0;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input logic [79:0] act, input logic [79:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge (R3).
    always @(negedge clk) begin
        if (!finished) begin
            check(key_end === m_key, "R3", "model key_end", key_end, m_key);
            check(ready === (m_phase == 32), "R3", "model ready",
                  {79'd0, ready}, {79'd0, m_phase == 32});
        end
    end

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Raise start with key k, count edges to ready.
    task automatic run_key(input logic [79:0] k, output int edges);
        key   = k;
        start = 1'b1;
        edges = 0;
        while (ready !== 1'b1 && edges < 60) begin
            @(negedge clk);
            edges++;
        end
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        finish_up();
    end

    initial begin : stim
        int          n;
        logic [79:0] first;
        logic [79:0] held;
        rst_n = 1'b0;
        step(4);
        check(ready === 1'b0, "R1", "ready in reset", {79'd0, ready}, 80'd0);
        check(key_end === '0, "R1", "key_end in reset", key_end, '0);
        rst_n = 1'b1;
        step(1);

        // R2 load, R4 timing, R5 zero key
        key = 80'h0123456789abcdef0123;
        start = 1'b1;
        step(1);
        check(key_end === 80'h0123456789abcdef0123, "R2", "loaded key",
              key_end, 80'h0123456789abcdef0123);
        start = 1'b0;
        step(2);
        run_key('0, n);
        check(n == 32, "R4", "edges to ready", 80'(n), 80'd32);
        check(key_end === EXP_ZERO, "R5", "zero key final", key_end, EXP_ZERO);
        first = key_end;

        // R7 hold while start high
        step(5);
        check(ready === 1'b1, "R7", "ready held", {79'd0, ready}, 80'd1);
        check(key_end === first, "R7", "key_end held", key_end, first);

        // R8 drop and hold in idle
        start = 1'b0;
        step(1);
        check(ready === 1'b0, "R8", "ready drop", {79'd0, ready}, 80'd0);
        key = 80'h5555aaaa5555aaaa5555;
        step(3);
        check(key_end === first, "R8", "idle hold", key_end, first);

        // R6 ones key
        run_key({80{1'b1}}, n);
        check(key_end === EXP_ONES, "R6", "ones key final", key_end, EXP_ONES);
        check(n == 32, "R4", "edges to ready ones", 80'(n), 80'd32);
        start = 1'b0;
        step(1);

        // R9 rerun same key after a different one
        run_key('0, n);
        check(key_end === first, "R9", "rerun identical", key_end, first);
        start = 1'b0;
        step(1);

        // R10 abandon mid-run, then restart
        key = {80{1'b1}};
        start = 1'b1;
        step(12);
        start = 1'b0;
        step(1);
        held = key_end;
        step(3);
        check(ready === 1'b0, "R10", "ready low after abort", {79'd0, ready}, 80'd0);
        check(key_end === held, "R10", "idle after abort", key_end, held);
        run_key({80{1'b1}}, n);
        check(n == 32, "R10", "restart full length", 80'(n), 80'd32);
        check(key_end === EXP_ONES, "R10", "restart result", key_end, EXP_ONES);
        start = 1'b0;
        step(1);

        // R11 key changed after load
        key = '0;
        start = 1'b1;
        step(6);
        key = {80{1'b1}};
        n = 6;
        while (ready !== 1'b1 && n < 60) begin
            step(1);
            n++;
        end
        check(key_end === EXP_ZERO, "R11", "key change ignored", key_end, EXP_ZERO);
        start = 1'b0;
        step(1);

        // R1 reset mid-run
        start = 1'b1;
        step(8);
        rst_n = 1'b0;
        step(1);
        check(key_end === '0, "R1", "mid-run reset key", key_end, '0);
        check(ready === 1'b0, "R1", "mid-run reset ready", {79'd0, ready}, 80'd0);
        rst_n = 1'b1;
        run_key({80{1'b1}}, n);
        check(key_end === EXP_ONES, "R9", "after reset result", key_end, EXP_ONES);
        start = 1'b0;
        step(2);
        finish_up();
    end

endmodule